// File: doc/BRIEF.md
# Two-Way Mailbox Register Interface

This peripheral links a CPU to a coprocessor through two one-way word queues. The CPU posts request words into an outbound queue, and the coprocessor drains that queue through a simple valid/pop port. The coprocessor returns reply words into an inbound queue through a push port, and the CPU collects them through a register read. Each word packs an aligned buffer address in bits 31:4 and a channel number in bits 3:0. The block carries every word unchanged, so software can match a reply to the request it posted.

Software polls one status register before each access. Bit 31 reports that the outbound queue cannot take another word. Bit 30 reports that no reply is waiting. The register window is decoded on a simple bus with address, read and write strobes, write data, read data and a ready signal. The window sits at offset 0xB880 from the peripheral base. Inside the window, the reply register is at +0x00, the status register is at +0x18 and the request register is at +0x20.

Top module: `mbox_regif`

## Requirements
- R1: After reset both queues are empty, the sticky overflow bit is clear, the status register reads 0x4000_0000 and cp_rx_valid_o is low.
- R2: A CPU write to the request register (0xB8A0) enqueues the 32-bit word. The coprocessor sees the words in posting order and unchanged: address bits 31:4 and channel bits 3:0 are both kept.
- R3: Status bit 31 reads 1 exactly when the outbound queue holds DEPTH (4) words.
- R4: Status bit 30 reads 1 exactly when the inbound queue holds no word.
- R5: A CPU write to the request register while the outbound queue is full is dropped. The queue contents are left as they were, and status bit 0 (the overflow flag) is set.
- R6: The overflow flag stays set until the CPU writes the status register (0xB898) with bit 0 = 1. A status write with bit 0 = 0 leaves the flag set.
- R7: A CPU read of the reply register (0xB880) returns the oldest inbound word and removes it in the same cycle the read is accepted. Words are returned in push order.
- R8: A CPU read of the reply register while the inbound queue is empty returns the last word that was returned, or zero if none has been returned since reset. The queue is left unchanged.
- R9: ready_o is high in every cycle in which rd_i or wr_i is high. A read of an unmapped address or of the request register returns 0, and a write to an unmapped address changes no state. Status bits 29:1 always read 0.
- R10: The coprocessor push is dropped while the inbound queue is full. cp_tx_full_o is high exactly when the inbound queue holds DEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Byte address relative to the peripheral base |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while rd_i is high |
| ready_o | output | 1 | Access accepted this cycle |
| cp_rx_valid_o | output | 1 | Outbound queue holds a word for the coprocessor |
| cp_rx_data_o | output | 32 | Oldest outbound word |
| cp_rx_pop_i | input | 1 | Coprocessor takes the oldest outbound word |
| cp_tx_push_i | input | 1 | Coprocessor pushes a reply word |
| cp_tx_data_i | input | 32 | Reply word |
| cp_tx_full_o | output | 1 | Inbound queue cannot accept a word |

## Verification
The assertions check several rules on every cycle: queue occupancy stays in bounds, and a push into a full queue leaves its head and level unchanged. Beyond that, the overflow flag is set by a dropped write and stays set until the clearing write, a reply read pops exactly one word, and an empty reply read leaves the inbound queue empty. Other behaviour can only be shown by the bench's scenarios: words keep their packed address and channel fields from end to end, FIFO ordering holds across a full fill and drain, status reads show the exact bit pattern, the empty read returns the previous value, and unmapped writes have no effect at the ports.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned OFS_REPLY  = 'h00;
  localparam int unsigned OFS_STATUS = 'h18;
  localparam int unsigned OFS_REQ    = 'h20;

  localparam int unsigned ST_FULL_BIT  = 31;
  localparam int unsigned ST_EMPTY_BIT = 30;
  localparam int unsigned ST_OVF_BIT   = 0;

  typedef struct packed {
    logic [27:0] buf_addr;
    logic [3:0]  chan;
  } mbox_word_t;

  typedef struct packed {
    logic rd_reply;
    logic rd_status;
    logic wr_req;
    logic wr_status;
  } mbox_acc_t;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] level_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] level_q;
  logic             do_push, do_pop;

  assign full_o  = (level_q == CNT_FULL);
  assign empty_o = (level_q == '0);
  assign level_o = level_q;
  assign data_o  = mem_q[rd_ptr_q];

  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= CNT_FULL); // R3

  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i |=> full_o && (data_o == $past(data_o))); // R5 R10

  AST_POP_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_o && pop_i && !push_i |=> level_q == $past(level_q) - 1'b1); // R7
endmodule

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BLOCK_BASE = 16'hB880
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output mbox_acc_t         acc_o
);
  localparam logic [ADDR_W-1:0] A_REPLY  = BLOCK_BASE + ADDR_W'(OFS_REPLY);
  localparam logic [ADDR_W-1:0] A_STATUS = BLOCK_BASE + ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_REQ    = BLOCK_BASE + ADDR_W'(OFS_REQ);

  always_comb begin
    acc_o           = '0;
    acc_o.rd_reply  = rd_i && (addr_i == A_REPLY);
    acc_o.rd_status = rd_i && (addr_i == A_STATUS);
    acc_o.wr_req    = wr_i && (addr_i == A_REQ);
    acc_o.wr_status = wr_i && (addr_i == A_STATUS);
  end
endmodule

// File: rtl/mbox_regif.sv
module mbox_regif
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DEPTH  = 4,
  parameter logic [ADDR_W-1:0] BLOCK_BASE = 16'hB880
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              ready_o,
  output logic              cp_rx_valid_o,
  output logic [31:0]       cp_rx_data_o,
  input  logic              cp_rx_pop_i,
  input  logic              cp_tx_push_i,
  input  logic [31:0]       cp_tx_data_i,
  output logic              cp_tx_full_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  mbox_acc_t        acc;
  logic             out_full, out_empty, in_full, in_empty;
  logic [CNT_W-1:0] out_level, in_level;
  logic [31:0]      in_head, last_q, status;
  logic             ovf_q;

  mbox_decode #(.ADDR_W(ADDR_W), .BLOCK_BASE(BLOCK_BASE)) u_dec (
    .addr_i (addr_i),
    .rd_i   (rd_i),
    .wr_i   (wr_i),
    .acc_o  (acc)
  );

  // CPU -> coprocessor
  mbox_fifo #(.WIDTH(32), .DEPTH(DEPTH)) u_out_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (acc.wr_req),
    .data_i  (wdata_i),
    .pop_i   (cp_rx_pop_i),
    .data_o  (cp_rx_data_o),
    .full_o  (out_full),
    .empty_o (out_empty),
    .level_o (out_level)
  );

  // coprocessor -> CPU
  mbox_fifo #(.WIDTH(32), .DEPTH(DEPTH)) u_in_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (cp_tx_push_i),
    .data_i  (cp_tx_data_i),
    .pop_i   (acc.rd_reply),
    .data_o  (in_head),
    .full_o  (in_full),
    .empty_o (in_empty),
    .level_o (in_level)
  );

  assign cp_rx_valid_o = ~out_empty;
  assign cp_tx_full_o  = in_full;
  assign ready_o       = rd_i | wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q  <= 1'b0;
      last_q <= '0;
    end else begin
      if (acc.wr_req && out_full)                  ovf_q <= 1'b1;
      else if (acc.wr_status && wdata_i[ST_OVF_BIT]) ovf_q <= 1'b0;
      if (acc.rd_reply && !in_empty) last_q <= in_head;
    end
  end

  always_comb begin
    status               = '0;
    status[ST_FULL_BIT]  = out_full;
    status[ST_EMPTY_BIT] = in_empty;
    status[ST_OVF_BIT]   = ovf_q;
  end

  // empty reply read returns the last popped word
  always_comb begin
    rdata_o = '0;
    if (acc.rd_reply)       rdata_o = in_empty ? last_q : in_head;
    else if (acc.rd_status) rdata_o = status;
  end

  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc.wr_req && out_full |=> ovf_q && out_full); // R5

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q && !(acc.wr_status && wdata_i[ST_OVF_BIT]) |=> ovf_q); // R6

  AST_EMPTY_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc.rd_reply && in_empty && !cp_tx_push_i |=> in_empty && $stable(last_q)); // R8

  AST_READ_POPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc.rd_reply && !in_empty && !cp_tx_push_i |=> in_level == $past(in_level) - 1'b1); // R7

  AST_OUT_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_level <= CNT_W'(DEPTH)); // R3
endmodule

// File: tb/mbox_regif_bench.sv
module mbox_regif_bench;
  localparam logic [15:0] A_REPLY  = 16'hB880;
  localparam logic [15:0] A_STATUS = 16'hB898;
  localparam logic [15:0] A_REQ    = 16'hB8A0;

  typedef enum logic [1:0] {OP_WR = 0, OP_RD = 1, OP_PUSH = 2, OP_POP = 3} op_e;
  typedef struct packed {
    op_e         op;
    logic [15:0] addr;
    logic [31:0] data;  // write data or expected value
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{OP_RD,   A_STATUS, 32'h4000_0000},  // R1 R4
    '{OP_WR,   A_REQ,    32'h1000_0008},
    '{OP_WR,   A_REQ,    32'h2000_0018},
    '{OP_POP,  16'h0,    32'h1000_0008},  // R2
    '{OP_POP,  16'h0,    32'h2000_0018},  // R2
    '{OP_PUSH, 16'h0,    32'hABCD_E008},
    '{OP_RD,   A_STATUS, 32'h0000_0000},  // R4
    '{OP_RD,   A_REPLY,  32'hABCD_E008},  // R7
    '{OP_RD,   A_STATUS, 32'h4000_0000},  // R7
    '{OP_RD,   A_REPLY,  32'hABCD_E008},  // R8
    '{OP_RD,   A_STATUS, 32'h4000_0000},  // R8
    '{OP_RD,   16'hB884, 32'h0000_0000}   // R9
  };

  logic        clk = 0, rst_n = 0;
  logic [15:0] addr = '0;
  logic        rd = 0, wr = 0, cp_pop = 0, cp_push = 0;
  logic [31:0] wdata = '0, cp_tdata = '0;
  logic [31:0] rdata, cp_rdata;
  logic        ready, cp_valid, cp_full;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  mbox_regif u_mbox_regif (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready),
    .cp_rx_valid_o(cp_valid), .cp_rx_data_o(cp_rdata), .cp_rx_pop_i(cp_pop),
    .cp_tx_push_i(cp_push), .cp_tx_data_i(cp_tdata), .cp_tx_full_o(cp_full)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    #1 check("R9 ready on write", {31'b0, ready}, 32'd1);
    @(negedge clk); wr = 0;
  endtask

  task automatic cpu_rd(string req, logic [15:0] a, logic [31:0] exp);
    @(negedge clk); addr = a; rd = 1;
    #1 check(req, rdata, exp);
    check("R9 ready on read", {31'b0, ready}, 32'd1);
    @(negedge clk); rd = 0;
  endtask

  task automatic cp_take(string req, logic [31:0] exp);
    @(negedge clk); #1;
    check({req, " valid"}, {31'b0, cp_valid}, 32'd1);
    check(req, cp_rdata, exp);
    cp_pop = 1;
    @(negedge clk); cp_pop = 0;
  endtask

  task automatic cp_give(logic [31:0] d);
    @(negedge clk); cp_tdata = d; cp_push = 1;
    @(negedge clk); cp_push = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_WR:   cpu_wr(VECS[i].addr, VECS[i].data);
        OP_RD:   cpu_rd("R4 R7 R8 R9 vector read", VECS[i].addr, VECS[i].data);
        OP_PUSH: cp_give(VECS[i].data);
        default: cp_take("R2 vector pop", VECS[i].data);
      endcase
    end

    // R3: fill outbound queue
    for (int i = 0; i < 4; i++) cpu_wr(A_REQ, 32'h0000_1000 | i);
    cpu_rd("R3 full flag", A_STATUS, 32'hC000_0000);
    // R5: dropped write sets overflow
    cpu_wr(A_REQ, 32'hDEAD_BEE5);
    cpu_rd("R5 overflow flag", A_STATUS, 32'hC000_0001);
    for (int i = 0; i < 4; i++) cp_take("R5 R2 order kept", 32'h0000_1000 | i);
    @(negedge clk); #1 check("R5 dropped word absent", {31'b0, cp_valid}, 32'd0);
    // R6: sticky until cleared with bit 0
    cpu_rd("R6 sticky", A_STATUS, 32'h4000_0001);
    cpu_wr(A_STATUS, 32'h0000_0000);
    cpu_rd("R6 no clear on bit0=0", A_STATUS, 32'h4000_0001);
    cpu_wr(A_STATUS, 32'h0000_0001);
    cpu_rd("R6 cleared", A_STATUS, 32'h4000_0000);

    // R10: inbound fill and drop
    for (int i = 0; i < 4; i++) cp_give(32'h5550_0008 + 32'(i) * 16);
    @(negedge clk); #1 check("R10 full", {31'b0, cp_full}, 32'd1);
    cp_give(32'h7777_7777);
    for (int i = 0; i < 4; i++) cpu_rd("R7 R10 drain order", A_REPLY, 32'h5550_0008 + 32'(i) * 16);
    cpu_rd("R8 empty read returns last", A_REPLY, 32'h5550_0038);
    cpu_rd("R10 dropped push absent", A_STATUS, 32'h4000_0000);

    // R9: unmapped write, request register reads zero
    cpu_wr(16'hB884, 32'hFFFF_FFFF);
    cpu_rd("R9 unmapped write no effect", A_STATUS, 32'h4000_0000);
    @(negedge clk); #1 check("R9 unmapped write no outbound", {31'b0, cp_valid}, 32'd0);
    cpu_wr(A_REQ, 32'h1234_5671);
    cpu_rd("R9 request reg reads zero", A_REQ, 32'h0);
    cp_take("R2 packed word", 32'h1234_5671);

    // R1: reset in mid-run
    cpu_wr(A_REQ, 32'hCAFE_0003);
    cpu_wr(A_STATUS, 32'h0);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1 check("R1 outbound empty", {31'b0, cp_valid}, 32'd0);
    cpu_rd("R1 status", A_STATUS, 32'h4000_0000);
    cpu_rd("R1 R8 last cleared", A_REPLY, 32'h0);

    finish_run();
  end
endmodule